// File: doc/BRIEF.md
# Auto-Incrementing Board Identification Reader

This block is a read-only identification port for an I/O-mapped peripheral bus that carries both byte and word accesses. Software learns what board it is talking to by reading a fixed byte table one entry at a time rather than through a flat register map. Two adjacent data addresses return the table entry under an internal pointer, and every read there moves the pointer forward. A third address sends the pointer back to the start of the table.

The table holds, in this order, a two-byte device code (60h then 61h), a two-byte vendor code (35h then 14h), two revision digits (least significant first), four reserved bytes, a short ASCII board-name string padded with NUL bytes, and FFh filler up to the last index. A word read at the lower data address returns two consecutive entries at once, low entry on the low byte lane. The first word read after a rewind is therefore 6160h.

All three addresses sit at fixed offsets above a base address that is set by a parameter. The block decodes those offsets, keeps the pointer, computes the table entries, and drives the read data bus.

Top module: `brd_ident_port`

## Requirements
- R1: After reset the pointer is 0, so the first byte read at the lower data address returns 0060h.
- R2: Table contents by index: 0 is 60h, 1 is 61h, 2 is 35h, 3 is 14h, 4 is the low revision digit (default 03h), 5 is the high revision digit (default 01h), 6 to 9 are 00h, 10 to 17 are the board-name characters "IDP-1616" first character first, 18 and 19 are 00h, and 20 to 255 are FFh.
- R3: A byte read (ioRd high, ioWide low) at BASE+800h or BASE+801h returns the entry at the pointer on rdData[7:0] with rdData[15:8] = 00h, and the pointer then grows by one.
- R4: A read at BASE+802h returns 0000h and sets the pointer to 0.
- R5: A word read (ioWide high) at BASE+800h returns entry p+1 on rdData[15:8] and entry p on rdData[7:0], and the pointer then grows by two.
- R6: ioWide has no effect at BASE+801h and BASE+802h: a wide read there behaves exactly as the byte read of R3 or R4.
- R7: The pointer stops at 255. Reads past it keep returning FFh per byte lane (FFFFh for a word), and a word read at 254 returns FFFFh and leaves the pointer at 255.
- R8: A cycle with ioWr high performs no access at any address, even with ioRd high: rdData is 0000h and the pointer is unchanged. Reads at any other address also return 0000h and leave the pointer unchanged.
- R9: With ioRd low, rdData is 0000h and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the pointer updates on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address of the current access |
| ioRd | input | 1 | Read strobe; one clock cycle is one access |
| ioWr | input | 1 | Write strobe; suppresses any access in its cycle |
| ioWide | input | 1 | High for a 16-bit access |
| rdData | output | 16 | Read data, combinational from the address, strobes and pointer |

## Verification
The embedded assertions follow the pointer on every cycle: a byte access moves it by one, a word access by two, both stopping at 255; a rewind clears it; a cycle without a decoded access leaves it untouched; and a write strobe never produces an access strobe. Only the bench's scenarios can show the table contents and their order, the lane placement of word data, and that writes and stray addresses really leave the stream where it was. The bench does this by streaming the whole table in byte and word form, at even and odd starting points, and by reading the next entry after every ignored stimulus.

// File: rtl/idp_pkg.sv
package idp_pkg;

  // Strobes from the access decoder to the pointer/datapath.
  typedef struct packed {
    logic stepOne;   // byte access at a data offset
    logic stepTwo;   // word access at the even data offset
    logic rewind;    // access at the rewind offset
    logic driveLo;   // put lane 0 on rdData[7:0]
    logic driveHi;   // put lane 1 on rdData[15:8]
  } idp_strobe_t;

  localparam int unsigned DATA_LO_OFS = 32'h800;
  localparam int unsigned DATA_HI_OFS = 32'h801;
  localparam int unsigned REWIND_OFS  = 32'h802;

endpackage

// File: rtl/idp_rom.sv
module idp_rom #(
  parameter int unsigned        PTR_W      = 8,
  parameter logic [15:0]        DEV_CODE   = 16'h6160,
  parameter logic [15:0]        VEN_CODE   = 16'h1435,
  parameter logic [7:0]         REV_LO     = 8'h03,
  parameter logic [7:0]         REV_HI     = 8'h01,
  parameter int unsigned        NAME_CHARS = 8,
  parameter logic [8*NAME_CHARS-1:0] NAME_TXT = "IDP-1616"
) (
  input  logic [PTR_W-1:0] idx,
  output logic [7:0]       entry
);

  localparam int NAME_BASE = 10;
  localparam int FILL_BASE = 20;
  localparam int NAME_END  = NAME_BASE + int'(NAME_CHARS);

  int pos;
  int chr;

  always_comb begin
    pos   = int'(idx);
    chr   = pos - NAME_BASE;
    entry = 8'hFF;
    if (pos == 0)                              entry = DEV_CODE[7:0];
    else if (pos == 1)                         entry = DEV_CODE[15:8];
    else if (pos == 2)                         entry = VEN_CODE[7:0];
    else if (pos == 3)                         entry = VEN_CODE[15:8];
    else if (pos == 4)                         entry = REV_LO;
    else if (pos == 5)                         entry = REV_HI;
    else if (pos < NAME_BASE)                  entry = 8'h00;
    else if (pos < NAME_END && pos < FILL_BASE)
      entry = NAME_TXT[8*(int'(NAME_CHARS)-1-chr) +: 8];
    else if (pos < FILL_BASE)                  entry = 8'h00;
  end

endmodule

// File: rtl/idp_ctrl.sv
module idp_ctrl
  import idp_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 16'h02E8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic              ioWide,
  output idp_strobe_t       stb
);

  localparam logic [ADDR_W-1:0] DATA_LO = BASE_ADDR + ADDR_W'(DATA_LO_OFS);
  localparam logic [ADDR_W-1:0] DATA_HI = BASE_ADDR + ADDR_W'(DATA_HI_OFS);
  localparam logic [ADDR_W-1:0] REWIND  = BASE_ADDR + ADDR_W'(REWIND_OFS);

  logic rdValid;
  logic hitLo, hitHi, hitRw;

  assign rdValid = ioRd & ~ioWr;
  assign hitLo   = (ioAddr == DATA_LO);
  assign hitHi   = (ioAddr == DATA_HI);
  assign hitRw   = (ioAddr == REWIND);

  always_comb begin
    stb         = '0;
    stb.stepTwo = rdValid & hitLo & ioWide;
    stb.stepOne = rdValid & ((hitLo & ~ioWide) | hitHi);
    stb.rewind  = rdValid & hitRw;
    stb.driveLo = stb.stepOne | stb.stepTwo;
    stb.driveHi = stb.stepTwo;
  end

  // R8: a write strobe never yields an access
  a_r8_write_no_access: assert property (@(posedge clk) disable iff (!rstN)
    ioWr |-> !(stb.stepOne || stb.stepTwo || stb.rewind));

  // R6: a wide access at the odd data offset is handled as a byte access
  a_r6_odd_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !ioWr && ioAddr == DATA_HI) |-> (stb.stepOne && !stb.stepTwo));

  // R4: at most one action per cycle
  a_r4_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.stepOne, stb.stepTwo, stb.rewind}));

endmodule

// File: rtl/idp_datapath.sv
module idp_datapath
  import idp_pkg::*;
#(
  parameter int unsigned        PTR_W      = 8,
  parameter logic [7:0]         REV_LO     = 8'h03,
  parameter logic [7:0]         REV_HI     = 8'h01,
  parameter int unsigned        NAME_CHARS = 8,
  parameter logic [8*NAME_CHARS-1:0] NAME_TXT = "IDP-1616"
) (
  input  logic        clk,
  input  logic        rstN,
  input  idp_strobe_t stb,
  output logic [15:0] rdData
);

  localparam int unsigned LANES = 2;
  localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}};

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptrNext;
  logic [PTR_W-1:0] laneIdx  [LANES];
  logic [7:0]       laneByte [LANES];

  function automatic logic [PTR_W-1:0] satAdd(input logic [PTR_W-1:0] base,
                                              input logic [1:0]       step);
    logic [PTR_W+1:0] sum;
    sum = {2'b00, base} + {{PTR_W{1'b0}}, step};
    return (sum > {2'b00, PTR_MAX}) ? PTR_MAX : sum[PTR_W-1:0];
  endfunction

  // One table reader per byte lane, each at its own offset from the pointer.
  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    assign laneIdx[g] = satAdd(ptr, 2'(g));
    idp_rom #(
      .PTR_W(PTR_W), .REV_LO(REV_LO), .REV_HI(REV_HI),
      .NAME_CHARS(NAME_CHARS), .NAME_TXT(NAME_TXT)
    ) u_rom (
      .idx  (laneIdx[g]),
      .entry(laneByte[g])
    );
  end

  always_comb begin
    ptrNext = ptr;
    if (stb.rewind)       ptrNext = '0;
    else if (stb.stepTwo) ptrNext = satAdd(ptr, 2'd2);
    else if (stb.stepOne) ptrNext = satAdd(ptr, 2'd1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else       ptr <= ptrNext;
  end

  assign rdData = {stb.driveHi ? laneByte[1] : 8'h00,
                   stb.driveLo ? laneByte[0] : 8'h00};

  // R4: a rewind access leaves the pointer at zero
  a_r4_rewind_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.rewind |=> (ptr == '0));

  // R3: a byte access below the top moves the pointer by exactly one
  a_r3_byte_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepOne && ptr != PTR_MAX) |=> (ptr == $past(ptr) + 1'b1));

  // R5: a word access well below the top moves the pointer by exactly two
  a_r5_word_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepTwo && ptr < PTR_MAX - 1'b1) |=> (ptr == $past(ptr) + 2'd2));

  // R7: the pointer holds at the top until a rewind
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (ptr == PTR_MAX && !stb.rewind) |=> (ptr == PTR_MAX));

  // R8, R9: no decoded access, no pointer movement
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.stepOne || stb.stepTwo || stb.rewind) |=> $stable(ptr));

endmodule

// File: rtl/brd_ident_port.sv
module brd_ident_port
  import idp_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 16,
  parameter logic [ADDR_W-1:0]  BASE_ADDR  = 16'h02E8,
  parameter int unsigned        PTR_W      = 8,
  parameter logic [7:0]         REV_LO     = 8'h03,
  parameter logic [7:0]         REV_HI     = 8'h01,
  parameter int unsigned        NAME_CHARS = 8,
  parameter logic [8*NAME_CHARS-1:0] NAME_TXT = "IDP-1616"
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic              ioWide,
  output logic [15:0]       rdData
);

  idp_strobe_t stb;

  idp_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .ioAddr(ioAddr),
    .ioRd  (ioRd),
    .ioWr  (ioWr),
    .ioWide(ioWide),
    .stb   (stb)
  );

  idp_datapath #(
    .PTR_W(PTR_W), .REV_LO(REV_LO), .REV_HI(REV_HI),
    .NAME_CHARS(NAME_CHARS), .NAME_TXT(NAME_TXT)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .rdData(rdData)
  );

endmodule

// File: tb/brd_ident_port_bench.sv
module brd_ident_port_bench;

  localparam logic [15:0] BASE = 16'h02E8;
  localparam logic [15:0] A_LO = BASE + 16'h0800;
  localparam logic [15:0] A_HI = BASE + 16'h0801;
  localparam logic [15:0] A_RW = BASE + 16'h0802;
  localparam string       NAME = "IDP-1616";

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioRd = 1'b0, ioWr = 1'b0, ioWide = 1'b0;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;
  int mPtr   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  brd_ident_port u_brd_ident_port (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd),
    .ioWr(ioWr), .ioWide(ioWide), .rdData(rdData)
  );

  function automatic logic [7:0] expByte(input int i);
    if (i == 0) return 8'h60;
    if (i == 1) return 8'h61;
    if (i == 2) return 8'h35;
    if (i == 3) return 8'h14;
    if (i == 4) return 8'h03;
    if (i == 5) return 8'h01;
    if (i >= 10 && i < 10 + NAME.len()) return NAME[i-10];
    if (i < 20) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic int sat(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic rd, input logic wr,
                        input logic wide, output logic [15:0] d);
    @(negedge clk);
    ioAddr = a; ioRd = rd; ioWr = wr; ioWide = wide;
    #5 d = rdData;
  endtask

  task automatic byteRead(input logic [15:0] a, input logic wide, input string req);
    logic [15:0] d;
    access(a, 1'b1, 1'b0, wide, d);
    check(req, d, {8'h00, expByte(mPtr)});
    mPtr = sat(mPtr + 1);
  endtask

  task automatic wordRead(input string req);
    logic [15:0] d;
    access(A_LO, 1'b1, 1'b0, 1'b1, d);
    check(req, d, {expByte(sat(mPtr + 1)), expByte(mPtr)});
    mPtr = sat(mPtr + 2);
  endtask

  task automatic rewind(input logic wide);
    logic [15:0] d;
    access(A_RW, 1'b1, 1'b0, wide, d);
    check("R4 rewind data", d, 16'h0000);
    mPtr = 0;
  endtask

  task automatic idle();
    @(negedge clk);
    ioAddr = '0; ioRd = 1'b0; ioWr = 1'b0; ioWide = 1'b0;
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    check("R9 data during reset", rdData, 16'h0000);
    rstN = 1'b1;
    idle();

    // R1: first read after reset
    byteRead(A_LO, 1'b0, "R1 first byte after reset");

    // R2, R3, R7: full byte stream across both data offsets and past the top
    rewind(1'b0);
    for (int i = 0; i < 300; i++)
      byteRead((i % 2 == 0) ? A_LO : A_HI, 1'b0, "R2 R3 R7 byte stream");

    // R5, R7: word stream from an even start, first word 6160h
    rewind(1'b0);
    access(A_LO, 1'b1, 1'b0, 1'b1, d);
    check("R5 first word", d, 16'h6160);
    mPtr = 2;
    for (int i = 0; i < 130; i++) wordRead("R5 R7 word stream");

    // R5: word reads from an odd pointer
    rewind(1'b0);
    byteRead(A_LO, 1'b0, "R3 odd setup");
    for (int i = 0; i < 12; i++) wordRead("R5 odd-start word");

    // R7: word at 254 then at 255
    rewind(1'b0);
    for (int i = 0; i < 254; i++) byteRead(A_HI, 1'b0, "R3 walk to 254");
    wordRead("R7 word at 254");
    wordRead("R7 word at 255");
    byteRead(A_LO, 1'b0, "R7 byte after top");

    // R6: wide flag at odd data offset and at rewind offset
    rewind(1'b1);
    byteRead(A_HI, 1'b1, "R6 wide at odd offset");
    byteRead(A_HI, 1'b1, "R6 wide at odd offset again");
    rewind(1'b1);
    byteRead(A_LO, 1'b0, "R6 pointer after wide rewind");

    // R8: writes and stray addresses
    rewind(1'b0);
    for (int i = 0; i < 3; i++) byteRead(A_LO, 1'b0, "R8 setup");
    access(A_LO, 1'b0, 1'b1, 1'b0, d); check("R8 write data lo", d, 16'h0000);
    access(A_HI, 1'b0, 1'b1, 1'b1, d); check("R8 write data hi", d, 16'h0000);
    access(A_RW, 1'b0, 1'b1, 1'b0, d); check("R8 write rewind", d, 16'h0000);
    access(A_RW, 1'b1, 1'b1, 1'b0, d); check("R8 read+write rewind", d, 16'h0000);
    access(A_LO, 1'b1, 1'b1, 1'b1, d); check("R8 read+write data", d, 16'h0000);
    access(BASE + 16'h0803, 1'b1, 1'b0, 1'b0, d); check("R8 stray 803", d, 16'h0000);
    access(BASE, 1'b1, 1'b0, 1'b1, d);            check("R8 stray base", d, 16'h0000);
    access(16'h0800, 1'b1, 1'b0, 1'b0, d);        check("R8 wrong base", d, 16'h0000);
    byteRead(A_LO, 1'b0, "R8 pointer unchanged");

    // R9: strobe low at a data offset
    access(A_LO, 1'b0, 1'b0, 1'b1, d); check("R9 no strobe data", d, 16'h0000);
    access(A_RW, 1'b0, 1'b0, 1'b0, d); check("R9 no strobe rewind", d, 16'h0000);
    byteRead(A_HI, 1'b0, "R9 pointer unchanged");

    idle();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule